// File: doc/BRIEF.md
# Buffered Synchronous Serial Port

A full-duplex synchronous serial port with two independent paths. On the transmit side the host writes a word into a data register. When the next frame begins, that word moves into a shift register and leaves on the serial output, most significant bit first. On the receive side the serial input fills a shift register. A finished word goes to an intermediate buffer and from there to the register the host reads. Because of this staging, one word can be arriving while an earlier one waits for the host.

Bit clocks and frame syncs come from outside the port, and each direction has its own pair. All port logic runs on one system clock, which oversamples the bit clocks and acts on their edges. Each direction programs its own word length. Each direction has a one-cycle interrupt pulse and a level event line for a DMA engine. Sticky flags record transmit underrun and receive overrun; only reset clears them.

Top module: `bsp_serial_port`

## Requirements
- R1: At a transmit bit-clock rising edge with the transmit frame sync high, the port loads the pending word and drives its MSB on `tx_dout` at once (zero bit delay). Each later rising edge drives the next lower bit. `tx_dout` changes only at rising edges.
- R2: At a receive bit-clock falling edge with the receive frame sync high, the port samples `rx_din` as the first (MSB) bit of a new word. Each later falling edge samples the next bit. A finished word appears in `rx_rdata` right-aligned, with zeros above the word length.
- R3: The word-length selects use the code 0=8, 1=12, 2=16, 3=20, 4=24, and 5, 6 or 7=32 bits. Transmit data bits above the word length are ignored.
- R4: The transmit and receive paths use only their own clock and frame-sync inputs. A receive frame leaves the transmit data register and `tx_dout` untouched.
- R5: A finished word moves from the buffer into the readable register only while that register is empty. `rx_ready` sets on that move and clears on `rx_rd_en`. A second word waits in the buffer until the read.
- R6: If a word completes while both the buffer and the readable register are full, the port discards that word and `rx_overrun` sets and stays set until reset.
- R7: If a transmit frame starts while the data register is empty, `tx_underrun` sets and stays set, and the port shifts out the previously sent word again.
- R8: `tx_ready` and `tx_evt` are high while the transmit data register is empty. `tx_int` pulses for one cycle each time a written word moves into the shift register.
- R9: `rx_int` pulses for one cycle each time a word moves into the readable register. `rx_evt` equals `rx_ready`.
- R10: After reset, `tx_dout`=0, `tx_ready`=1, `rx_ready`=0, and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wlen_sel | input | 3 | Transmit word-length code |
| rx_wlen_sel | input | 3 | Receive word-length code |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_wr_en | input | 1 | Write strobe for the transmit data register |
| tx_wdata | input | DW | Transmit word |
| tx_dout | output | 1 | Serial data out |
| tx_ready | output | 1 | Transmit data register empty |
| tx_int | output | 1 | Transmit interrupt pulse |
| tx_evt | output | 1 | Transmit DMA event level |
| tx_underrun | output | 1 | Sticky underrun flag |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial data in |
| rx_rd_en | input | 1 | Read strobe for the readable register |
| rx_rdata | output | DW | Readable receive word |
| rx_ready | output | 1 | Readable register full |
| rx_int | output | 1 | Receive interrupt pulse |
| rx_evt | output | 1 | Receive DMA event level |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
Transmit is looped back into receive, and a table of words runs through every word-length code. The table includes asymmetric values such as a lone LSB and a set MSB, which show whether the bit order is reversed. One word carries bits above its length, which shows whether the length masks the data. Three frames in a row with no read separate correct two-deep staging from a single buffer, and show whether the dropped word is the newest or the oldest. A receive-only frame and a frame with nothing written show whether the clocks are independent and whether an underrun repeats the last word or sends zeros.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int LEN_W = 6;

    function automatic logic [LEN_W-1:0] wlen_of(input logic [2:0] sel);
        logic [LEN_W-1:0] len;
        case (sel)
            3'd0:    len = 6'd8;
            3'd1:    len = 6'd12;
            3'd2:    len = 6'd16;
            3'd3:    len = 6'd20;
            3'd4:    len = 6'd24;
            default: len = 6'd32;
        endcase
        return len;
    endfunction
endpackage

// File: rtl/bsp_tx_path.sv
module bsp_tx_path #(
    parameter int DW = 32,
    localparam int CW = bsp_pkg::LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wlen,
    input  logic          bclk,
    input  logic          fs,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          dout,
    output logic          ready,
    output logic          intr,
    output logic          underrun
);
    typedef struct packed {
        logic          bclk_prev;
        logic [DW-1:0] data;
        logic          full;
        logic [DW-1:0] last;
        logic [DW-1:0] sreg;
        logic [CW-1:0] cnt;
        logic          active;
        logic          dout;
        logic          intr;
        logic          und;
    } tx_state_t;

    tx_state_t st_q, st_d;
    logic      rise;
    logic [DW-1:0] word, aligned;

    assign rise = bclk & ~st_q.bclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.bclk_prev = bclk;
        st_d.intr      = 1'b0;
        word           = st_q.last;
        aligned        = '0;
        if (rise) begin
            if (fs) begin
                if (st_q.full) begin
                    word      = st_q.data;
                    st_d.intr = 1'b1;
                end else begin
                    st_d.und  = 1'b1;
                end
                st_d.last   = word;
                st_d.full   = 1'b0;
                aligned     = word << (DW - 32'(wlen));
                st_d.dout   = aligned[DW-1];
                st_d.sreg   = aligned << 1;
                st_d.cnt    = CW'(1);
                st_d.active = 1'b1;
            end else if (st_q.active) begin
                if (st_q.cnt == wlen) begin
                    st_d.active = 1'b0;
                    st_d.dout   = 1'b0;
                end else begin
                    st_d.dout = st_q.sreg[DW-1];
                    st_d.sreg = st_q.sreg << 1;
                    st_d.cnt  = st_q.cnt + 1'b1;
                end
            end
        end
        if (wr_en) begin
            st_d.data = wdata;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout     = st_q.dout;
    assign ready    = ~st_q.full;
    assign intr     = st_q.intr;
    assign underrun = st_q.und;

    AST_TX_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(dout)); // R1
    AST_TX_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R7
    AST_TX_INT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        intr |=> !intr); // R8
endmodule

// File: rtl/bsp_rx_path.sv
module bsp_rx_path #(
    parameter int DW = 32,
    localparam int CW = bsp_pkg::LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wlen,
    input  logic          bclk,
    input  logic          fs,
    input  logic          din,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          ready,
    output logic          intr,
    output logic          overrun
);
    typedef struct packed {
        logic          bclk_prev;
        logic [DW-1:0] rsr;
        logic [CW-1:0] cnt;
        logic          active;
        logic [DW-1:0] stage;
        logic          stage_full;
        logic [DW-1:0] hold;
        logic          ready;
        logic          intr;
        logic          ovr;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic      fall;

    assign fall = ~bclk & st_q.bclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.bclk_prev = bclk;
        st_d.intr      = 1'b0;
        if (fall) begin
            if (fs) begin
                st_d.rsr    = {{(DW-1){1'b0}}, din};
                st_d.cnt    = CW'(1);
                st_d.active = 1'b1;
            end else if (st_q.active) begin
                st_d.rsr = {st_q.rsr[DW-2:0], din};
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (rd_en && st_q.ready) st_d.ready = 1'b0;
        if (st_q.stage_full && !st_q.ready) begin
            st_d.hold       = st_q.stage;
            st_d.ready      = 1'b1;
            st_d.intr       = 1'b1;
            st_d.stage_full = 1'b0;
        end
        if (fall && st_d.active && st_d.cnt == wlen) begin
            st_d.active = 1'b0;
            if (!st_d.stage_full) begin
                st_d.stage      = st_d.rsr;
                st_d.stage_full = 1'b1;
            end else begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata   = st_q.hold;
    assign ready   = st_q.ready;
    assign intr    = st_q.intr;
    assign overrun = st_q.ovr;

    AST_RX_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R6
    AST_RX_OVERRUN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(ready)); // R6
    AST_RX_INT_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> intr); // R9
    AST_RX_HOLD_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rd_en) |=> $stable(rdata)); // R5
endmodule

// File: rtl/bsp_serial_port.sv
module bsp_serial_port #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    tx_wlen_sel,
    input  logic [2:0]    rx_wlen_sel,
    input  logic          tx_bclk,
    input  logic          tx_fs,
    input  logic          tx_wr_en,
    input  logic [DW-1:0] tx_wdata,
    output logic          tx_dout,
    output logic          tx_ready,
    output logic          tx_int,
    output logic          tx_evt,
    output logic          tx_underrun,
    input  logic          rx_bclk,
    input  logic          rx_fs,
    input  logic          rx_din,
    input  logic          rx_rd_en,
    output logic [DW-1:0] rx_rdata,
    output logic          rx_ready,
    output logic          rx_int,
    output logic          rx_evt,
    output logic          rx_overrun
);
    localparam int CW = bsp_pkg::LEN_W;

    logic [CW-1:0] tx_len, rx_len;

    assign tx_len = bsp_pkg::wlen_of(tx_wlen_sel);
    assign rx_len = bsp_pkg::wlen_of(rx_wlen_sel);

    bsp_tx_path #(.DW(DW)) i_tx (
        .clk(clk), .rst_n(rst_n), .wlen(tx_len), .bclk(tx_bclk), .fs(tx_fs),
        .wr_en(tx_wr_en), .wdata(tx_wdata), .dout(tx_dout), .ready(tx_ready),
        .intr(tx_int), .underrun(tx_underrun)
    );

    bsp_rx_path #(.DW(DW)) i_rx (
        .clk(clk), .rst_n(rst_n), .wlen(rx_len), .bclk(rx_bclk), .fs(rx_fs),
        .din(rx_din), .rd_en(rx_rd_en), .rdata(rx_rdata), .ready(rx_ready),
        .intr(rx_int), .overrun(rx_overrun)
    );

    assign tx_evt = tx_ready;
    assign rx_evt = rx_ready;
endmodule

// File: tb/test_bsp_serial_port.sv
module test_bsp_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tx_wlen_sel = 3'd0, rx_wlen_sel = 3'd0;
    logic        tx_bclk = 1'b0, tx_fs = 1'b0, tx_wr_en = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic        tx_dout, tx_ready, tx_int, tx_evt, tx_underrun;
    logic        rx_bclk = 1'b0, rx_fs = 1'b0, rx_rd_en = 1'b0;
    logic        rx_din;
    logic [31:0] rx_rdata;
    logic        rx_ready, rx_int, rx_evt, rx_overrun;

    logic        lb = 1'b1, src_bit = 1'b0;
    logic [31:0] src = '0, cap = '0;
    int          nchk = 0, nfail = 0, ntx = 0, nrx = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign rx_din = lb ? tx_dout : src_bit;

    bsp_serial_port #(.DW(32)) i_bsp_serial_port (.*);

    always @(posedge clk) begin
        if (tx_int) ntx++;
        if (rx_int) nrx++;
    end

    localparam logic [34:0] VECS [8] = '{
        {3'd0, 32'h0000_00A5}, {3'd1, 32'h0000_0ABC}, {3'd2, 32'h0000_8001},
        {3'd3, 32'h000F_0F0F}, {3'd4, 32'h0012_3456}, {3'd5, 32'hDEAD_BEEF},
        {3'd7, 32'h0000_0001}, {3'd0, 32'hFFFF_FF3C}
    };

    function automatic int len_of(input logic [2:0] s);
        case (s)
            3'd0: return 8;  3'd1: return 12; 3'd2: return 16;
            3'd3: return 20; 3'd4: return 24; default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); tx_wdata = d; tx_wr_en = 1'b1;
        @(negedge clk); tx_wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); rx_rd_en = 1'b1;
        @(negedge clk); rx_rd_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input int n, input bit do_tx, input bit do_rx);
        cap = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (do_tx) begin tx_fs = (i == 0); tx_bclk = 1'b1; end
            if (do_rx) begin rx_fs = (i == 0); rx_bclk = 1'b1; end
            src_bit = src[n-1-i];
            @(negedge clk); cap = {cap[30:0], tx_dout};
            @(negedge clk); tx_bclk = 1'b0; rx_bclk = 1'b0;
            @(negedge clk);
        end
        tx_fs = 1'b0; rx_fs = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int t0, r0, n;
        logic [31:0] d, m, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 tx_dout", 32'(tx_dout), 32'd0);
        chk("R10 tx_ready", 32'(tx_ready), 32'd1);
        chk("R10 rx_ready", 32'(rx_ready), 32'd0);
        chk("R10 flags", {30'd0, tx_underrun, rx_overrun}, 32'd0);

        // table walk: loopback through every length code
        lb = 1'b1;
        foreach (VECS[k]) begin
            tx_wlen_sel = VECS[k][34:32]; rx_wlen_sel = VECS[k][34:32];
            d = VECS[k][31:0]; n = len_of(VECS[k][34:32]); m = mask_of(n);
            wr(d);
            chk("R8 tx_ready after write", 32'(tx_ready), 32'd0);
            t0 = ntx; r0 = nrx;
            frame(n, 1'b1, 1'b1);
            chk("R1 R3 serial word MSB first", cap & m, d & m);
            chk("R2 R3 rx_rdata", rx_rdata, d & m);
            chk("R5 rx_ready set", 32'(rx_ready), 32'd1);
            chk("R9 rx_evt level", 32'(rx_evt), 32'(rx_ready));
            chk("R8 tx_int one pulse", 32'(ntx - t0), 32'd1);
            chk("R9 rx_int one pulse", 32'(nrx - r0), 32'd1);
            chk("R8 tx_evt after load", 32'(tx_evt), 32'd1);
            rd();
            chk("R5 rx_ready cleared by read", 32'(rx_ready), 32'd0);
        end

        // R5 / R6: three words, no read in between
        tx_wlen_sel = 3'd0; rx_wlen_sel = 3'd0;
        wr(32'h11); frame(8, 1'b1, 1'b1);
        wr(32'h22); frame(8, 1'b1, 1'b1);
        chk("R5 first word held", rx_rdata, 32'h11);
        chk("R6 no overrun yet", 32'(rx_overrun), 32'd0);
        wr(32'h33); frame(8, 1'b1, 1'b1);
        chk("R6 overrun set", 32'(rx_overrun), 32'd1);
        chk("R6 readable untouched", rx_rdata, 32'h11);
        rd();
        chk("R5 buffered second word", rx_rdata, 32'h22);
        chk("R5 ready after refill", 32'(rx_ready), 32'd1);
        rd();
        chk("R6 newest discarded", 32'(rx_ready), 32'd0);
        chk("R6 overrun sticky", 32'(rx_overrun), 32'd1);

        // R4: receive-only frame with transmit idle
        wr(32'h55);
        prev = 32'(tx_dout);
        lb = 1'b0; src = 32'h96;
        frame(8, 1'b0, 1'b1);
        chk("R4 rx word on own clock", rx_rdata, 32'h96);
        chk("R4 tx data register kept", 32'(tx_ready), 32'd0);
        chk("R4 tx_dout untouched", 32'(tx_dout), prev);
        chk("R4 no underrun", 32'(tx_underrun), 32'd0);
        rd();

        // R7: drain, then a frame with nothing written
        lb = 1'b1;
        frame(8, 1'b1, 1'b1);
        chk("R4 pending tx word sent", cap & 32'hFF, 32'h55);
        rd();
        t0 = ntx;
        frame(8, 1'b1, 1'b1);
        chk("R7 underrun set", 32'(tx_underrun), 32'd1);
        chk("R7 last word repeated", cap & 32'hFF, 32'h55);
        chk("R7 no tx_int on underrun", 32'(ntx - t0), 32'd0);
        rd();
        frame(8, 1'b1, 1'b0);
        chk("R7 underrun sticky", 32'(tx_underrun), 32'd1);

        finish_run();
    end
endmodule